// File: doc/BRIEF.md
# Half-Duplex SPI Response Header Synchronizer

This block is an SPI master for a peripheral that answers in half-duplex fashion. After a start pulse it asserts chip select and shifts bytes one at a time, using SPI mode 0 with the most significant bit first. It first sends the requested number of payload bytes. While receive bytes are still owed, it keeps the clock running by sending all-ones filler bytes. Every byte the peripheral clocks back goes through a gate. The gate drops bytes until a programmable marker byte appears, then drops the marker itself. It then passes the requested number of following bytes to a byte-wide output stream.

The transfer ends when both the transmit count and the receive count are used up. Chip select is held for one more SCLK period and then released, and `done` pulses at that same clock. The marker is typically 0xEC. It is taken from `hdr_byte` at each start, so one instance can serve peripherals that use different markers. The transfer unit is always one byte. No hardware packet counter is involved, so the two counts alone set the length. There is no timeout: a peripheral that never sends the marker keeps the block clocking filler.

The controller is a four-state machine. ST_IDLE waits for `start`. ST_LOAD hands one byte to the shift engine. ST_SHIFT waits while the engine moves eight bits. ST_TAIL holds chip select for the closing SCLK period. Transitions: ST_IDLE goes to ST_LOAD on start with a nonzero count, or to ST_TAIL on start with both counts zero. ST_LOAD always goes to ST_SHIFT. ST_SHIFT goes back to ST_LOAD when a byte completes and work remains, or to ST_TAIL when a byte completes and both counts are exhausted. ST_TAIL goes to ST_IDLE when the tail interval expires, raising `done`.

Top module: `hdsync_spi_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, and done, rx_valid and tx_pop are all 0.
- R2: Bytes use SPI mode 0, most significant bit first. sclk idles low and each level lasts HALF clock cycles. mosi is stable across each rising sclk edge, and miso is sampled on that edge. Each byte takes eight sclk pulses.
- R3: The first tx_len bytes on mosi are the tx_data values, in order. tx_pop pulses exactly once per payload byte, and tx_data is taken on the clock at which tx_pop is high.
- R4: Every byte sent after the payload is used up is the filler value 0xFF.
- R5: Received bytes before the first byte equal to hdr_byte are discarded. They are neither output nor counted against rx_len.
- R6: The first received byte equal to hdr_byte is consumed and is not output.
- R7: After the marker has matched, a received byte equal to hdr_byte is ordinary data and is output.
- R8: Exactly rx_len bytes following the marker are output in arrival order, each shown for one cycle with rx_valid high. Later bytes are not output.
- R9: The marker hunt also runs during the payload phase. The number of bytes clocked is the larger of tx_len and (marker position + 1 + rx_len). When rx_len is 0, it is tx_len.
- R10: cs_n is low from the clock after start until done. done is a one-cycle pulse, and cs_n rises at the same clock exactly 2*HALF cycles after the last falling sclk edge.
- R11: A start pulse during a transfer is ignored, and so are changes to tx_len and rx_len during a transfer.
- R12: A start with tx_len and rx_len both 0 produces no sclk pulses, and done follows 2*HALF cycles later.
- R13: Each start re-arms the marker hunt, whatever the previous transfer saw.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a transfer when idle |
| tx_len | input | CW | Number of payload bytes to send |
| rx_len | input | CW | Number of reply bytes to deliver after the marker |
| hdr_byte | input | 8 | Marker value to hunt for (typically 0xEC) |
| tx_data | input | 8 | Current payload byte, advanced by tx_pop |
| tx_pop | output | 1 | Payload byte taken this cycle |
| rx_data | output | 8 | Delivered reply byte |
| rx_valid | output | 1 | rx_data is valid this cycle |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench plays the peripheral. It reassembles mosi bytes, and it predicts the output stream and the transfer length by searching the reply script for the marker.

The corner cases it targets are these:
- A marker arriving while the payload is still being sent. A design that stopped hunting until the payload ended would skip the real marker and deliver the wrong bytes.
- A second marker value inside the data. A design that hunted again would swallow it.
- A receive count that ends before the payload does. A design that delivered on would emit extra bytes.
- Zero counts, and a start pulse mid-transfer. A design that got these wrong would restart or stretch the frame.

The tail timing of done and cs_n is compared cycle-exactly. A design with an extra register in that path would be one cycle late.

// File: rtl/hdsync_pkg.sv
package hdsync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_TAIL
    } xfer_state_t;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/hdsync_byte_engine.sv
module hdsync_byte_engine #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] load_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HCW-1:0] HLAST = HCW'(HALF - 1);

    logic           busy_q;
    logic           sclk_q;
    logic [HCW-1:0] hcnt_q;
    logic [2:0]     bit_q;
    logic [7:0]     txsh_q;
    logic [7:0]     rxsh_q;
    logic           tick;

    assign tick      = busy_q && (hcnt_q == HLAST);
    assign byte_done = tick && sclk_q && (bit_q == 3'd7);
    assign rx_byte   = rxsh_q;
    assign sclk      = sclk_q;
    assign mosi      = txsh_q[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            hcnt_q <= '0;
            bit_q  <= '0;
            txsh_q <= '0;
            rxsh_q <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            hcnt_q <= '0;
            bit_q  <= '0;
            txsh_q <= load_byte;
        end else if (busy_q) begin
            hcnt_q <= tick ? '0 : hcnt_q + 1'b1;
            if (tick) begin
                sclk_q <= ~sclk_q;
                if (!sclk_q) begin
                    rxsh_q <= {rxsh_q[6:0], miso};
                end else if (bit_q == 3'd7) begin
                    busy_q <= 1'b0;
                end else begin
                    bit_q  <= bit_q + 1'b1;
                    txsh_q <= {txsh_q[6:0], 1'b0};
                end
            end
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q); // R2
    AST_NO_RELOAD_MIDBYTE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !go); // R2
endmodule

// File: rtl/hdsync_rx_gate.sv
module hdsync_rx_gate #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [CW-1:0] want_len,
    input  logic [7:0]    marker,
    input  logic          stb,
    input  logic [7:0]    byte_in,
    output logic [7:0]    out_data,
    output logic          out_valid,
    output logic          rx_finished
);
    logic          hunting_q;
    logic [CW-1:0] rem_q;
    logic [7:0]    marker_q;

    // true when, after the byte now strobed, nothing is owed
    assign rx_finished = (rem_q == '0) || (!hunting_q && (rem_q == CW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hunting_q <= 1'b0;
            rem_q     <= '0;
            marker_q  <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (arm) begin
                hunting_q <= 1'b1;
                rem_q     <= want_len;
                marker_q  <= marker;
            end else if (stb) begin
                if (hunting_q) begin
                    if (byte_in == marker_q) begin
                        hunting_q <= 1'b0;
                    end
                end else if (rem_q != '0) begin
                    out_data  <= byte_in;
                    out_valid <= 1'b1;
                    rem_q     <= rem_q - 1'b1;
                end
            end
        end
    end

    AST_NO_DATA_WHILE_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !hunting_q); // R5
    AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rem_q == CW'($past(rem_q) - 1'b1))); // R8
    AST_HUNT_ENDS_ON_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hunting_q) |-> ($past(byte_in) == marker_q)); // R6
endmodule

// File: rtl/hdsync_spi_master.sv
module hdsync_spi_master
    import hdsync_pkg::*;
#(
    parameter int HALF = 2,
    parameter int CW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] tx_len,
    input  logic [CW-1:0] rx_len,
    input  logic [7:0]    hdr_byte,
    input  logic [7:0]    tx_data,
    output logic          tx_pop,
    output logic [7:0]    rx_data,
    output logic          rx_valid,
    output logic          done,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n
);
    localparam int TAIL_CYC = 2 * HALF;
    localparam int GW = $clog2(TAIL_CYC) + 1;
    localparam logic [GW-1:0] GLAST = GW'(TAIL_CYC - 1);

    xfer_state_t   state_q, state_d;
    logic [CW-1:0] tx_rem_q;
    logic [GW-1:0] gap_q;
    logic          cs_n_q;
    logic          done_q;
    logic          eng_go;
    logic [7:0]    eng_byte;
    logic          byte_done;
    logic [7:0]    rx_byte;
    logic          rx_finished;
    logic          arm;
    logic          finish;

    assign arm      = (state_q == ST_IDLE) && start;
    assign eng_go   = (state_q == ST_LOAD);
    assign tx_pop   = (state_q == ST_LOAD) && (tx_rem_q != '0);
    assign eng_byte = (tx_rem_q != '0) ? tx_data : FILL_BYTE;
    assign finish   = (tx_rem_q == '0) && rx_finished;
    assign cs_n     = cs_n_q;
    assign done     = done_q;

    hdsync_byte_engine #(.HALF(HALF)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (eng_go),
        .load_byte (eng_byte),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    hdsync_rx_gate #(.CW(CW)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .want_len    (rx_len),
        .marker      (hdr_byte),
        .stb         (byte_done),
        .byte_in     (rx_byte),
        .out_data    (rx_data),
        .out_valid   (rx_valid),
        .rx_finished (rx_finished)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ((tx_len == '0) && (rx_len == '0)) ? ST_TAIL : ST_LOAD;
            end
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (byte_done) state_d = finish ? ST_TAIL : ST_LOAD;
            ST_TAIL:  if (gap_q == GLAST) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // registered outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q   <= 1'b1;
            done_q   <= 1'b0;
            tx_rem_q <= '0;
            gap_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cs_n_q   <= 1'b0;
                    tx_rem_q <= tx_len;
                    gap_q    <= '0;
                end
                ST_LOAD: if (tx_rem_q != '0) tx_rem_q <= tx_rem_q - 1'b1;
                ST_SHIFT: gap_q <= '0;
                ST_TAIL: begin
                    gap_q <= gap_q + 1'b1;
                    if (gap_q == GLAST) begin
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (cs_n && $past(!cs_n))); // R10
    AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n); // R2
    AST_POP_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !cs_n); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state_q != ST_IDLE)) |=> (tx_rem_q <= $past(tx_rem_q))); // R11
endmodule

// File: tb/tb_hdsync_spi_master.sv
`timescale 1ns/1ps
module tb_hdsync_spi_master;
    localparam int HALF = 2;
    localparam int CW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] tx_len = '0;
    logic [CW-1:0] rx_len = '0;
    logic [7:0]    hdr_byte = 8'hEC;
    logic [7:0]    tx_data;
    logic          tx_pop;
    logic [7:0]    rx_data;
    logic          rx_valid;
    logic          done;
    logic          sclk;
    logic          mosi;
    logic          miso;
    logic          cs_n;

    always #10 clk = ~clk;

    hdsync_spi_master #(.HALF(HALF), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_len(tx_len),
        .rx_len(rx_len), .hdr_byte(hdr_byte), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
        .done(done), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    // reference model state
    logic [7:0] txq[$];
    logic [7:0] scr[$];
    logic [7:0] exp_rx[$];
    int  m_txlen, m_nbytes;
    int  pidx, pend, pops;
    int  sidx, sbit;
    int  mbits, bytes_seen, rx_idx;
    logic [7:0] mbyte;
    int  last_fall;
    bit  in_xfer = 0, fin = 0, mon_on = 0;
    logic sclk_p = 1'b0;

    function automatic logic [7:0] sbyte(int i);
        return (i < scr.size()) ? scr[i] : 8'h00;
    endfunction

    assign tx_data = (pidx < txq.size()) ? txq[pidx] : 8'h00;
    assign miso    = sbyte(sidx)[7 - sbit];

    task automatic chk(bit ok, string req, int act, int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mon_on) begin
            if (pend != 0) pidx++;
            pend = tx_pop ? 1 : 0;
            if (tx_pop) pops++;
            if (sclk && !sclk_p) begin
                mbyte = {mbyte[6:0], mosi};
                mbits++;
                sbit++;
                if (sbit == 8) begin sbit = 0; sidx++; end
                if (mbits == 8) begin
                    mbits = 0;
                    if (bytes_seen < m_txlen)
                        chk(mbyte == txq[bytes_seen], "R3 mosi payload byte", mbyte, txq[bytes_seen]);
                    else
                        chk(mbyte == 8'hFF, "R4 mosi filler byte", mbyte, 8'hFF);
                    bytes_seen++;
                end
            end
            if (!sclk && sclk_p) last_fall = cyc;
            sclk_p = sclk;
            if (rx_valid) begin
                if (rx_idx < exp_rx.size())
                    chk(rx_data == exp_rx[rx_idx], "R8 rx byte value", rx_data, exp_rx[rx_idx]);
                else
                    chk(1'b0, "R8 extra rx byte", rx_data, 0);
                rx_idx++;
            end
            if (done) begin
                chk(cs_n == 1'b1, "R10 cs_n released at done", cs_n, 1);
                chk(in_xfer, "R10 done outside transfer", 0, 1);
                chk(cyc == last_fall + 2*HALF, "R10 done timing", cyc - last_fall, 2*HALF);
                chk(bytes_seen == m_nbytes, "R9 byte count", bytes_seen, m_nbytes);
                chk(rx_idx == exp_rx.size(), "R8 rx count", rx_idx, exp_rx.size());
                chk(pops == m_txlen, "R3 tx_pop count", pops, m_txlen);
                in_xfer = 0;
                fin = 1;
            end else begin
                chk(cs_n == !in_xfer, "R10 cs_n level", cs_n, !in_xfer);
            end
            if (!in_xfer) chk(sclk == 1'b0, "R2 sclk idle low", sclk, 0);
        end
    end

    task automatic run(input int tl, input int rl, input logic [7:0] hdr, input bit poke);
        int k;
        int c;
        @(posedge clk);
        hdr_byte = hdr;
        tx_len = CW'(tl);
        rx_len = CW'(rl);
        exp_rx.delete();
        k = -1;
        for (int i = 0; i < scr.size(); i++) if (k < 0 && scr[i] == hdr) k = i + 1;
        if (rl != 0 && k >= 0)
            for (int i = 0; i < rl; i++) exp_rx.push_back(sbyte(k + i));
        m_txlen = tl;
        m_nbytes = (rl == 0) ? tl : ((tl > k + rl) ? tl : k + rl);
        pidx = 0; pend = 0; pops = 0; sidx = 0; sbit = 0;
        mbits = 0; bytes_seen = 0; rx_idx = 0; mbyte = 0; fin = 0;
        @(negedge clk);
        c = cyc;
        start = 1'b1;
        @(posedge clk);
        in_xfer = 1;
        last_fall = c + 1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;           // R11: must be ignored mid-transfer
            tx_len = CW'(1);
            rx_len = CW'(9);
            @(negedge clk);
            start = 1'b0;
        end
        while (!fin) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0 && cs_n == 1'b1, "R11 no restart after done", {sclk, cs_n}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
        chk(sclk == 1'b0 && done == 1'b0, "R1 reset sclk/done", {sclk, done}, 0);
        chk(rx_valid == 1'b0 && tx_pop == 1'b0, "R1 reset rx_valid/tx_pop", {rx_valid, tx_pop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;

        // R5 R6 R7: garbage, marker, data containing the marker value
        txq = '{8'hA5, 8'h3C};
        scr = '{8'h00, 8'h00, 8'h11, 8'hEC, 8'hD1, 8'hEC, 8'h7E};
        run(2, 3, 8'hEC, 0);

        // R9 R13: marker during payload, rx count ends before payload
        txq = '{8'h01, 8'h80, 8'hFE, 8'h5A, 8'hC3};
        scr = '{8'hEC, 8'h55, 8'h66, 8'h77, 8'h88};
        run(5, 1, 8'hEC, 0);

        // R4 R5: receive only, custom marker, long filler run
        txq = {};
        scr = '{8'hFF, 8'hFF, 8'hEC, 8'h5A, 8'h01, 8'h02};
        run(0, 2, 8'h5A, 0);

        // R9: transmit only
        txq = '{8'h96, 8'h69, 8'h0F};
        scr = '{8'hEC, 8'h12};
        run(3, 0, 8'hEC, 0);

        // R12: both counts zero
        txq = {};
        scr = {};
        run(0, 0, 8'hEC, 0);

        // R11 R13: start and count changes mid-transfer are ignored
        txq = '{8'h24, 8'h42};
        scr = '{8'h33, 8'h44, 8'h99, 8'h33, 8'hEC, 8'hAB, 8'hCD, 8'hEF, 8'h10};
        run(2, 4, 8'hEC, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule